// File: doc/BRIEF.md
# NAND flash host command sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus and turns one operation request into the full series of bus cycles for that operation. A request carries an opcode, a 17-bit page (row) address, a 12-bit column address and a byte count. The block then drives chip enable, the command and address latch strobes, the write and read strobes and the shared I/O lines. It waits on the ready/busy line wherever the flash array is working, and it moves payload bytes through a write byte stream and a read byte stream, each with valid/ready flow control.

Every bus cycle runs in a small timing engine. Four clock-count inputs set the low and high times of the write strobe and the read strobe. The sequencer above the engine chooses the cycle kind and the byte for each step. Program and erase end with an automatic status read, and bit 0 of the returned status byte comes back as a fail flag beside the done pulse. The ready/busy input is assumed to be already synchronous to the clock.

Top module: `nfc_seq_top`

## Requirements
- R1: Chip enable is high while no operation runs. Every command, address or data byte is placed on nf_io_out with nf_io_oe high and chip enable low, and the flash latches it on the rising edge of the write strobe. The read and write strobes are never low together.
- R2: A command cycle has nf_cle=1 and nf_ale=0. An address cycle has nf_ale=1 and nf_cle=0. A data cycle has both low. Both strobes and the output byte stay unchanged while the write strobe is low.
- R3: Opcode 0 (page read) sends command 00h, column low byte, column high byte, row bits 7:0, row bits 15:8, row bit 16, then command 30h. The block then waits for ready/busy and delivers req_len bytes on the read stream.
- R4: Opcode 1 (page program) sends 80h and the same five address bytes, then req_len bytes taken from the write stream as data cycles, then 10h. After the busy wait it sends 70h, reads one status byte, and pulses done with done_fail equal to status bit 0. The write stream is only ready during a program.
- R5: Opcode 2 (block erase) sends 60h, the three row bytes only, and D0h. After the busy wait it performs the same automatic status read as R4.
- R6: Opcode 3 (reset) sends only FFh and then pulses done. Opcode 4 (status) sends only 70h and then returns one status byte on the read stream.
- R7: Opcode 5 (read ID) sends 90h, one address byte 00h, and then reads req_len bytes onto the read stream.
- R8: A column address above 2111 is clamped to 2111 (address bytes 3Fh, 08h) before it is sent.
- R9: The write strobe stays low for exactly max(1,t_wl) clocks, and the read strobe for exactly max(1,t_rl) clocks. Within a sequence, back-to-back write cycles rise max(1,t_wl)+max(1,t_wh)+1 clocks apart.
- R10: After the second command of read, program or erase, no strobe pulse occurs and no done pulse is given until ready/busy has gone low and then high again.
- R11: A read-stream byte stays valid and unchanged until it is taken with rd_ready, and all bytes arrive in order. done is a single-cycle pulse, and req_ready is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_op | input | 3 | Opcode: 0 read, 1 program, 2 erase, 3 reset, 4 status, 5 read ID |
| req_row | input | 17 | Page address |
| req_col | input | 12 | Column address |
| req_len | input | 12 | Payload byte count |
| t_wl | input | 4 | Write strobe low clocks (0 acts as 1) |
| t_wh | input | 4 | Write strobe high clocks (0 acts as 1) |
| t_rl | input | 4 | Read strobe low clocks (0 acts as 1) |
| t_rh | input | 4 | Read strobe high clocks (0 acts as 1) |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Write stream byte taken |
| wr_data | input | 8 | Write stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Read stream consumer ready |
| rd_data | output | 8 | Read stream byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_fail | output | 1 | Status bit 0 of program/erase, valid with done |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven onto the flash I/O lines |
| nf_io_oe | output | 1 | Output enable for nf_io_out |
| nf_io_in | input | 8 | Byte read from the flash I/O lines |
| nf_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The embedded assertions check bus rules on every cycle. These are the latch strobes being mutually exclusive, the two strobes never low together, the strobes and byte stable through a write-strobe low time, chip enable low around every strobe, the column staying inside the page, the write stream being used only by program, the read-stream hold under back-pressure, and the engine staying idle during busy waits. The byte order of each operation can only be shown by the bench's flash model, which logs every latched byte. The same holds for the busy handshake timing, the clamped column bytes, the exact pulse widths and spacing for several timing settings, and the status-derived fail flag.

// File: rtl/nfc_pkg.sv
// Shared types for the NAND host sequencer: request opcodes, the kind of a
// single bus cycle and the fixed command bytes. Assumes an 8-bit bus.
package nfc_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_RESET  = 3'd3,
        OP_STATUS = 3'd4,
        OP_READID = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_WR   = 2'd2,
        K_RD   = 2'd3
    } kind_e;

    localparam logic [7:0] C_READ1  = 8'h00;
    localparam logic [7:0] C_READ2  = 8'h30;
    localparam logic [7:0] C_PROG1  = 8'h80;
    localparam logic [7:0] C_PROG2  = 8'h10;
    localparam logic [7:0] C_ERASE1 = 8'h60;
    localparam logic [7:0] C_ERASE2 = 8'hD0;
    localparam logic [7:0] C_RESET  = 8'hFF;
    localparam logic [7:0] C_STATUS = 8'h70;
    localparam logic [7:0] C_ID     = 8'h90;
endpackage

// File: rtl/nfc_bus_cycle.sv
// Single bus-cycle engine. On start it runs one command, address, write-data
// or read-data cycle: strobe low for max(1,T_low) clocks, then high for
// max(1,T_high) clocks, then a one-cycle done. CLE/ALE and the output byte are
// held for the whole cycle. Read data is captured on the clock that raises RE#.
// Assumes start is only raised while idle is high.
module nfc_bus_cycle
    import nfc_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  kind_e         kind,
    input  logic [7:0]    wbyte,
    input  logic [TW-1:0] t_wl,
    input  logic [TW-1:0] t_wh,
    input  logic [TW-1:0] t_rl,
    input  logic [TW-1:0] t_rh,
    input  logic [7:0]    io_in,
    output logic          idle,
    output logic          done,
    output logic [7:0]    rbyte,
    output logic          cle,
    output logic          ale,
    output logic          we_n,
    output logic          re_n,
    output logic [7:0]    io_out,
    output logic          io_oe
);
    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;

    ph_e           ph;
    logic [TW-1:0] cnt;
    logic          is_rd;
    logic          start_rd;

    function automatic logic [TW-1:0] eff(input logic [TW-1:0] t);
        return (t == '0) ? TW'(1) : t;
    endfunction

    assign start_rd = (kind == K_RD);
    assign idle     = (ph == P_IDLE);
    assign done     = (ph == P_HIGH) && (cnt == '0);

    // Phase sequencing, pulse counting and read capture for one bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= P_IDLE;
            cnt    <= '0;
            is_rd  <= 1'b0;
            cle    <= 1'b0;
            ale    <= 1'b0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            io_out <= 8'h00;
            io_oe  <= 1'b0;
            rbyte  <= 8'h00;
        end else begin
            case (ph)
                P_IDLE: if (start) begin
                    ph     <= P_LOW;
                    is_rd  <= start_rd;
                    cle    <= (kind == K_CMD);
                    ale    <= (kind == K_ADDR);
                    io_out <= wbyte;
                    io_oe  <= !start_rd;
                    we_n   <= start_rd;
                    re_n   <= !start_rd;
                    cnt    <= (start_rd ? eff(t_rl) : eff(t_wl)) - TW'(1);
                end
                P_LOW: begin
                    if (cnt == '0) begin
                        ph   <= P_HIGH;
                        we_n <= 1'b1;
                        re_n <= 1'b1;
                        if (is_rd) rbyte <= io_in;
                        cnt  <= (is_rd ? eff(t_rh) : eff(t_wh)) - TW'(1);
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        ph    <= P_IDLE;
                        cle   <= 1'b0;
                        ale   <= 1'b0;
                        io_oe <= 1'b0;
                    end else begin
                        cnt <= cnt - TW'(1);
                    end
                end
            endcase
        end
    end

    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    p_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(cle) && $stable(ale) && $stable(io_out)));
endmodule

// File: rtl/nfc_seq.sv
// Operation sequencer. It accepts one request while idle and steps through
// command, address, data, busy-wait and status phases, requesting one bus
// cycle at a time from the engine. It clamps the column to the page and
// buffers one read byte for the read stream. Assumes nf_rb_n is synchronous.
module nfc_seq
    import nfc_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int ROW_W      = 17,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             done_fail,
    output logic             nf_ce_n,
    input  logic             nf_rb_n,
    output logic             cyc_start,
    output kind_e            cyc_kind,
    output logic [7:0]       cyc_byte,
    input  logic             cyc_idle,
    input  logic             cyc_done,
    input  logic [7:0]       cyc_rbyte
);
    localparam int COL_MAX = PAGE_BYTES - 1;
    localparam logic [2:0] AI_ID = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WLO, S_WHI,
        S_RDATA, S_RHOLD, S_SCMD, S_SREAD, S_DONE
    } st_e;

    st_e              st;
    op_e              op;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic [LEN_W-1:0] left;
    logic [2:0]       aidx;
    logic [7:0]       rbuf;
    logic             fail;
    logic [15:0]      col16;
    logic [23:0]      row24;
    logic [7:0]       abyte, cmd1, cmd2;
    logic             want;

    assign col16 = 16'(col);
    assign row24 = 24'(row);

    // Address byte for the current index: two column bytes, then three row bytes.
    always_comb begin
        case (aidx)
            3'd0:    abyte = col16[7:0];
            3'd1:    abyte = col16[15:8];
            3'd2:    abyte = row24[7:0];
            3'd3:    abyte = row24[15:8];
            3'd4:    abyte = row24[23:16];
            default: abyte = 8'h00;
        endcase
    end

    // First and second command bytes for the latched opcode.
    always_comb begin
        case (op)
            OP_READ:   cmd1 = C_READ1;
            OP_PROG:   cmd1 = C_PROG1;
            OP_ERASE:  cmd1 = C_ERASE1;
            OP_RESET:  cmd1 = C_RESET;
            OP_STATUS: cmd1 = C_STATUS;
            default:   cmd1 = C_ID;
        endcase
        case (op)
            OP_READ: cmd2 = C_READ2;
            OP_PROG: cmd2 = C_PROG2;
            default: cmd2 = C_ERASE2;
        endcase
    end

    // Bus-cycle request: kind and byte follow the current step.
    always_comb begin
        want     = 1'b0;
        cyc_kind = K_CMD;
        cyc_byte = 8'h00;
        case (st)
            S_CMD1:  begin want = 1'b1; cyc_byte = cmd1; end
            S_ADDR:  begin want = 1'b1; cyc_kind = K_ADDR; cyc_byte = abyte; end
            S_WDATA: begin want = wr_valid; cyc_kind = K_WR; cyc_byte = wr_data; end
            S_CMD2:  begin want = 1'b1; cyc_byte = cmd2; end
            S_SCMD:  begin want = 1'b1; cyc_byte = C_STATUS; end
            S_RDATA, S_SREAD: begin want = 1'b1; cyc_kind = K_RD; end
            default: want = 1'b0;
        endcase
    end

    assign cyc_start = want && cyc_idle;
    assign wr_ready  = (st == S_WDATA) && cyc_idle;
    assign req_ready = (st == S_IDLE);
    assign rd_valid  = (st == S_RHOLD);
    assign rd_data   = rbuf;
    assign done      = (st == S_DONE);
    assign done_fail = (st == S_DONE) && fail;
    assign nf_ce_n   = (st == S_IDLE);

    // Step sequencing across command, address, data, busy and status phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            op   <= OP_READ;
            col  <= '0;
            row  <= '0;
            left <= '0;
            aidx <= '0;
            rbuf <= 8'h00;
            fail <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid && req_op <= 3'd5) begin
                    op   <= op_e'(req_op);
                    row  <= req_row;
                    col  <= (req_col > COL_W'(COL_MAX)) ? COL_W'(COL_MAX) : req_col;
                    left <= req_len;
                    fail <= 1'b0;
                    st   <= S_CMD1;
                end
                S_CMD1: if (cyc_done) begin
                    case (op)
                        OP_READ, OP_PROG: begin aidx <= 3'd0; st <= S_ADDR; end
                        OP_ERASE:  begin aidx <= 3'd2; st <= S_ADDR; end
                        OP_READID: begin aidx <= AI_ID; st <= S_ADDR; end
                        OP_STATUS: begin left <= LEN_W'(1); st <= S_RDATA; end
                        default:   st <= S_DONE;
                    endcase
                end
                S_ADDR: if (cyc_done) begin
                    if (aidx == AI_ID)
                        st <= (left == '0) ? S_DONE : S_RDATA;
                    else if (aidx == 3'd4)
                        st <= (op == OP_PROG && left != '0) ? S_WDATA : S_CMD2;
                    else
                        aidx <= aidx + 3'd1;
                end
                S_WDATA: if (cyc_done) begin
                    left <= left - LEN_W'(1);
                    if (left == LEN_W'(1)) st <= S_CMD2;
                end
                S_CMD2: if (cyc_done) st <= S_WLO;
                S_WLO:  if (!nf_rb_n) st <= S_WHI;
                S_WHI:  if (nf_rb_n) begin
                    if (op == OP_READ) st <= (left == '0) ? S_DONE : S_RDATA;
                    else               st <= S_SCMD;
                end
                S_RDATA: if (cyc_done) begin
                    rbuf <= cyc_rbyte;
                    st   <= S_RHOLD;
                end
                S_RHOLD: if (rd_ready) begin
                    left <= left - LEN_W'(1);
                    st   <= (left == LEN_W'(1)) ? S_DONE : S_RDATA;
                end
                S_SCMD:  if (cyc_done) st <= S_SREAD;
                S_SREAD: if (cyc_done) begin
                    fail <= cyc_rbyte[0];
                    st   <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    p_done_then_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    p_col_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |-> (col <= COL_W'(COL_MAX)));
    p_wr_only_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (op == OP_PROG));
    p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WLO || st == S_WHI) |-> (cyc_idle && !done));
endmodule

// File: rtl/nfc_seq_top.sv
// Top of the NAND host sequencer: joins the operation sequencer to the bus
// cycle engine and exposes the flash bus pins. Assumes one flash device and
// an externally synchronised ready/busy input.
module nfc_seq_top
    import nfc_pkg::*;
#(
    parameter int COL_W      = 12,
    parameter int ROW_W      = 17,
    parameter int LEN_W      = 12,
    parameter int TW         = 4,
    parameter int PAGE_BYTES = 2112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic [TW-1:0]    t_wl,
    input  logic [TW-1:0]    t_wh,
    input  logic [TW-1:0]    t_rl,
    input  logic [TW-1:0]    t_rh,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             done_fail,
    output logic             nf_ce_n,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_io_out,
    output logic             nf_io_oe,
    input  logic [7:0]       nf_io_in,
    input  logic             nf_rb_n
);
    logic       cyc_start, cyc_idle, cyc_done;
    kind_e      cyc_kind;
    logic [7:0] cyc_byte, cyc_rbyte;

    nfc_seq #(
        .COL_W(COL_W), .ROW_W(ROW_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .done_fail(done_fail),
        .nf_ce_n(nf_ce_n), .nf_rb_n(nf_rb_n),
        .cyc_start(cyc_start), .cyc_kind(cyc_kind), .cyc_byte(cyc_byte),
        .cyc_idle(cyc_idle), .cyc_done(cyc_done), .cyc_rbyte(cyc_rbyte)
    );

    nfc_bus_cycle #(.TW(TW)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .start(cyc_start), .kind(cyc_kind), .wbyte(cyc_byte),
        .t_wl(t_wl), .t_wh(t_wh), .t_rl(t_rl), .t_rh(t_rh),
        .io_in(nf_io_in),
        .idle(cyc_idle), .done(cyc_done), .rbyte(cyc_rbyte),
        .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .io_out(nf_io_out), .io_oe(nf_io_oe)
    );

    p_ce_around_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
    p_oe_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> nf_io_oe);
endmodule

// File: tb/tb_nfc_seq_top.sv
module tb_nfc_seq_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, req_valid, req_ready, wr_valid, wr_ready, rd_valid, rd_ready;
    logic [2:0]  req_op;
    logic [16:0] req_row;
    logic [11:0] req_col, req_len;
    logic [3:0]  t_wl, t_wh, t_rl, t_rh;
    logic [7:0]  wr_data, rd_data, nf_io_out, nf_io_in;
    logic        done, done_fail, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe, nf_rb_n;

    nfc_seq_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .t_wl(t_wl), .t_wh(t_wh), .t_rl(t_rl), .t_rh(t_rh),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .done_fail(done_fail), .nf_ce_n(nf_ce_n), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
        .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb_n(nf_rb_n)
    );

    int n_chk = 0, n_bad = 0, ncyc = 0;
    int log_t[64], log_b[64], log_at[64], log_wl[64];
    int log_n = 0;
    int exp_t[64], exp_b[64];
    int exp_n = 0;
    int we_lc = 0, re_lc = 0, re_exp = 1, re_bad = 0, re_cnt = 0;
    logic stat_mode = 1'b0, id_mode = 1'b0, fail_flag = 1'b0, bsy_req = 1'b0;
    int ptr = 0, bcnt = 0, viol = 0;
    int wr_pat[16];
    int wr_n = 0, wr_idx = 0, rd_n = 0, done_cnt = 0;
    int cap[16];
    logic last_fail = 1'b0;

    // Flash model: bytes are latched on the rising write strobe.
    always @(posedge nf_we_n) begin
        if (nf_ce_n === 1'b0) begin
            int ty;
            ty = nf_cle ? (nf_ale ? 3 : 0) : (nf_ale ? 1 : 2);
            if (log_n < 64) begin
                log_t[log_n] = ty; log_b[log_n] = int'(nf_io_out);
                log_at[log_n] = ncyc; log_wl[log_n] = we_lc; log_n++;
            end
            if (ty == 0) begin
                ptr = 0;
                stat_mode = (nf_io_out == 8'h70);
                id_mode = (nf_io_out == 8'h90);
                if (nf_io_out == 8'h30 || nf_io_out == 8'h10 || nf_io_out == 8'hD0) bsy_req = 1'b1;
            end
        end
    end

    always @(posedge nf_re_n) begin
        if (nf_ce_n === 1'b0) begin
            if (re_lc != re_exp) re_bad++;
            re_cnt++;
            ptr++;
        end
    end

    assign nf_io_in = stat_mode ? (8'hE0 | {7'b0, fail_flag}) :
                      id_mode ? (8'hD0 + 8'(ptr)) : (8'h40 + 8'(ptr));
    assign nf_rb_n = !(bcnt > 0 && bcnt < 10);

    // Per-cycle bookkeeping, busy model and both byte streams, at the falling edge.
    always @(negedge clk) begin
        ncyc++;
        if (nf_we_n === 1'b0) we_lc++; else we_lc = 0;
        if (nf_re_n === 1'b0) re_lc++; else re_lc = 0;
        if (bcnt > 0 && (nf_re_n === 1'b0 || nf_we_n === 1'b0 || done === 1'b1)) viol++;
        if (bsy_req) begin bsy_req = 1'b0; bcnt = 12; end
        else if (bcnt > 0) bcnt--;
        wr_valid = (wr_idx < wr_n);
        wr_data = 8'(wr_pat[wr_idx % 16]);
        rd_ready = (ncyc % 3 != 0);
        #1;
        if (wr_valid && wr_ready) wr_idx++;
        if (rd_valid && rd_ready && rd_n < 16) begin cap[rd_n] = int'(rd_data); rd_n++; end
        if (done === 1'b1) begin done_cnt++; last_fail = done_fail; end
    end

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic e(input int t, input int b);
        exp_t[exp_n] = t; exp_b[exp_n] = b; exp_n++;
    endtask

    task automatic check_log(input string tag);
        chk({tag, " byte count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk($sformatf("%s entry %0d", tag, i), log_t[i] * 256 + log_b[i], exp_t[i] * 256 + exp_b[i]);
    endtask

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic set_t(input int wl, input int wh, input int rl, input int rh);
        t_wl = 4'(wl); t_wh = 4'(wh); t_rl = 4'(rl); t_rh = 4'(rh);
        re_exp = eff(rl);
    endtask

    task automatic run_op(input int op, input int row, input int col, input int len);
        @(posedge clk); #2;
        log_n = 0; rd_n = 0; wr_idx = 0; done_cnt = 0; viol = 0; re_bad = 0; re_cnt = 0; exp_n = 0;
        req_op = 3'(op); req_row = 17'(row); req_col = 12'(col); req_len = 12'(len);
        req_valid = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        #2;
    endtask

    task automatic check_timing(input string tag, input int wl, input int wh);
        for (int i = 0; i < log_n; i++) chk({tag, " R9 we low width"}, log_wl[i], eff(wl));
        for (int i = 1; i < log_n; i++)
            if (log_t[i] == 1 && log_t[i-1] == 1)
                chk({tag, " R9 we spacing"}, log_at[i] - log_at[i-1], eff(wl) + eff(wh) + 1);
    endtask

    task automatic t_reset_state();
        chk("R1 ce high after reset", int'(nf_ce_n), 1);
        chk("R1 we high after reset", int'(nf_we_n), 1);
        chk("R1 re high after reset", int'(nf_re_n), 1);
        chk("R2 cle/ale low after reset", int'({nf_cle, nf_ale}), 0);
        chk("R11 ready idle after reset", int'(req_ready), 1);
        chk("R11 no done after reset", int'(done), 0);
    endtask

    task automatic t_read();
        set_t(2, 1, 1, 2);
        run_op(0, 'h12345, 'h123, 4);
        e(0, 'h00); e(1, 'h23); e(1, 'h01); e(1, 'h45); e(1, 'h23); e(1, 'h01); e(0, 'h30);
        check_log("R3 R2 read");
        chk("R3 read byte count", rd_n, 4);
        for (int i = 0; i < 4 && i < rd_n; i++) chk("R11 R3 read data", cap[i], 'h40 + i);
        chk("R10 read busy quiet", viol, 0);
        chk("R9 read re width", re_bad, 0);
        chk("R11 single done", done_cnt, 1);
        check_timing("read", 2, 1);
        chk("R1 ce high after read", int'(nf_ce_n), 1);
    endtask

    task automatic t_prog(input int len, input logic fl);
        fail_flag = fl;
        wr_pat[0] = 'h11; wr_pat[1] = 'h22; wr_pat[2] = 'h33;
        wr_n = len;
        set_t(3, 2, 1, 1);
        run_op(1, 'h0ABCD, 5, len);
        e(0, 'h80); e(1, 'h05); e(1, 'h00); e(1, 'hCD); e(1, 'hAB); e(1, 'h00);
        for (int i = 0; i < len; i++) e(2, wr_pat[i]);
        e(0, 'h10); e(0, 'h70);
        check_log("R4 program");
        chk("R4 write bytes taken", wr_idx, len);
        chk("R4 fail flag", int'(last_fail), int'(fl));
        chk("R4 status read cycles", re_cnt, 1);
        chk("R10 program busy quiet", viol, 0);
        check_timing("prog", 3, 2);
        wr_n = 0;
    endtask

    task automatic t_erase();
        fail_flag = 1'b0;
        set_t(0, 0, 0, 0);
        run_op(2, 'h1FFC0, 'h7FF, 9);
        e(0, 'h60); e(1, 'hC0); e(1, 'hFF); e(1, 'h01); e(0, 'hD0); e(0, 'h70);
        check_log("R5 erase");
        chk("R5 erase pass", int'(last_fail), 0);
        chk("R10 erase busy quiet", viol, 0);
        chk("R9 zero counts re width", re_bad, 0);
        check_timing("erase", 0, 0);
    endtask

    task automatic t_reset_status();
        set_t(1, 1, 1, 1);
        run_op(3, 0, 0, 3);
        e(0, 'hFF);
        check_log("R6 reset");
        chk("R6 reset no read data", rd_n, 0);
        chk("R6 reset done", done_cnt, 1);
        fail_flag = 1'b1;
        run_op(4, 0, 0, 7);
        e(0, 'h70);
        check_log("R6 status");
        chk("R6 status byte count", rd_n, 1);
        chk("R6 status byte", cap[0], 'hE1);
        fail_flag = 1'b0;
    endtask

    task automatic t_readid();
        set_t(1, 1, 3, 1);
        run_op(5, 'h1FFFF, 'h555, 2);
        e(0, 'h90); e(1, 'h00);
        check_log("R7 read id");
        chk("R7 id byte count", rd_n, 2);
        chk("R7 id byte 0", cap[0], 'hD0);
        chk("R7 id byte 1", cap[1], 'hD1);
        chk("R9 re width 3", re_bad, 0);
    endtask

    task automatic t_clamp();
        set_t(1, 2, 1, 1);
        run_op(0, 'h00001, 'hFFF, 0);
        e(0, 'h00); e(1, 'h3F); e(1, 'h08); e(1, 'h01); e(1, 'h00); e(1, 'h00); e(0, 'h30);
        check_log("R8 clamp");
        chk("R8 no data when length zero", rd_n, 0);
        chk("R10 clamp busy quiet", viol, 0);
        check_timing("clamp", 1, 2);
    endtask

    initial begin
        #(10 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_row = '0; req_col = '0; req_len = '0;
        t_wl = 4'd1; t_wh = 4'd1; t_rl = 4'd1; t_rh = 4'd1;
        repeat (3) @(posedge clk);
        #2;
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_read();
        t_prog(3, 1'b0);
        t_prog(0, 1'b1);
        t_erase();
        t_reset_status();
        t_readid();
        t_clamp();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule